// File: doc/BRIEF.md
# Multi-Mode Waveform Timer

An 8-bit timer/counter core for a peripheral subsystem. The counter advances only in cycles where the `tick` input is high; the prescaler or clock-select stage that makes that tick sits outside the block. A 3-bit mode field chooses how the counter runs and where it turns round: free-running, cleared on compare, fast PWM with a single slope, or phase-correct PWM that counts up and back down. The turning point, called TOP here, is either the counter's maximum or the value of compare channel A.

Two compare channels, A and B, each hold a compare value and drive one waveform pin. A 2-bit action field per channel decides what a match does to the pin. In the PWM modes, compare writes go first into a shadow register and take effect at a point in the count period that depends on the mode. This keeps the duty cycle free of glitches. The block keeps three sticky event flags: overflow, match A and match B. Software clears them by writing ones. A small synchronous register port gives access to the counter, both compare values, the control byte and the flags. It also provides a strobe that forces a compare action. None of the pins carries a data stream, so the port has no handshake. A write is accepted in the cycle in which `reg_wr` is high, and a read returns data combinationally from `reg_addr`. The parameter `CNT_W` must be at least 8.

Top module: `wave_timer`

## Requirements
- R1: Register addresses are 0 for the counter, 1 for compare A and 2 for compare B (a read of either returns the value in effect), 3 for control, 4 for flags and 5 for the force strobe. Address 5 reads as zero. Control bits [2:0] are the mode, bits [5:4] are the action for A and bits [7:6] are the action for B. Flag bit 0 is overflow, bit 1 is match A and bit 2 is match B. Force bit 0 is channel A and bit 1 is channel B.
- R2: After reset, the counter, both compare values, the control byte, the flags, both pins and both pin enables are all zero. The counter direction is up.
- R3: In mode 000, the counter steps up by one on each tick, holds when there is no tick, wraps from 0xFF to 0x00, and sets the overflow flag on that wrap.
- R4: In mode 010, the counter returns to 0 on the tick in which it equals compare A. The overflow flag sets only on a tick taken at 0xFF.
- R5: Fast PWM wraps from TOP to 0. Mode 011 uses TOP = 0xFF and sets overflow at 0xFF. Mode 111 uses TOP = compare A and sets overflow at TOP.
- R6: Phase-correct PWM (001 with TOP = 0xFF, 101 with TOP = compare A) counts up to TOP, then down to 0, then up again. The overflow flag sets on the tick taken at 0 while counting down.
- R7: A compare write takes effect on the next edge in modes 000 and 010. In phase-correct modes it is held until the tick taken at TOP. In fast PWM modes it is held until the tick that wraps to 0.
- R8: A flag sets when its event occurs on a tick: counter equal to that channel's compare value, or overflow. Writing 1 to a flag bit clears it. A hardware set in the same cycle wins over the clear.
- R9: In modes 000 and 010, on a match, action 01 toggles the pin, 10 drives it low and 11 drives it high. Action 00 leaves the pin unchanged. The pin enable is high whenever the action is not 00.
- R10: In fast PWM, action 10 drives the pin low on a match and high on the wrap to 0, with the wrap winning when both happen in one tick. Action 11 is the inverse. Action 01 toggles on a match.
- R11: In phase-correct PWM, action 10 drives the pin low on a match while counting up and high on a match while counting down. Action 11 is the inverse. Action 01 toggles on a match.
- R12: A force strobe applies the channel's action as if a match had occurred, in non-PWM modes only. It sets no flag and leaves the counter unchanged.
- R13: A counter write loads the value with no count in that cycle. Compare matches in the next cycle are suppressed.
- R14: The reserved modes 100 and 110 hold the counter on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from the clock-select stage |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| pin_a | output | 1 | Channel A waveform |
| pin_b | output | 1 | Channel B waveform |
| oe_a | output | 1 | Channel A pin enable |
| oe_b | output | 1 | Channel B pin enable |
| flags | output | 3 | Sticky flags {match B, match A, overflow} |

## Verification
The collisions that matter most are a hardware flag set meeting a software write-1-to-clear in the same cycle, and a fast PWM wrap meeting a match when compare equals TOP. The bench provokes the first directly: it clears the overflow flag on the very tick that wraps the counter, and expects the flag to stay set. The second, along with forces landing on live matches, is provoked by random stimulus that biases compare values toward 0xFF and toward small TOP values. Every cycle, the pins, flags, counter and active compare values are compared with a bench model built from the requirements.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [2:0] {
    M_NORMAL    = 3'b000,
    M_PC_FULL   = 3'b001,
    M_CTC       = 3'b010,
    M_FAST_FULL = 3'b011,
    M_RSV_A     = 3'b100,
    M_PC_VAR    = 3'b101,
    M_RSV_B     = 3'b110,
    M_FAST_VAR  = 3'b111
  } wt_mode_e;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } wt_act_e;

  localparam logic [2:0] A_CNT   = 3'd0;
  localparam logic [2:0] A_CMPA  = 3'd1;
  localparam logic [2:0] A_CMPB  = 3'd2;
  localparam logic [2:0] A_CTRL  = 3'd3;
  localparam logic [2:0] A_FLAGS = 3'd4;
  localparam logic [2:0] A_FORCE = 3'd5;

  function automatic logic is_phase(wt_mode_e m);
    return (m == M_PC_FULL) || (m == M_PC_VAR);
  endfunction

  function automatic logic is_fast(wt_mode_e m);
    return (m == M_FAST_FULL) || (m == M_FAST_VAR);
  endfunction

  function automatic logic is_pwm(wt_mode_e m);
    return is_phase(m) || is_fast(m);
  endfunction

  function automatic logic is_rsv(wt_mode_e m);
    return (m == M_RSV_A) || (m == M_RSV_B);
  endfunction

  function automatic logic is_var_top(wt_mode_e m);
    return (m == M_CTC) || (m == M_PC_VAR) || (m == M_FAST_VAR);
  endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wt_mode_e         mode,
  input  logic [CNT_W-1:0] top_var,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic             step,
  output logic             upd_ev,
  output logic             bottom_ev,
  output logic             ovf_ev
);

  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] top, cnt_n;
  logic             up_n, at_top;

  assign top    = is_var_top(mode) ? top_var : MAXV;
  assign step   = tick & ~ld & ~is_rsv(mode);
  assign at_top = (cnt == top);

  always_comb begin
    cnt_n     = cnt;
    up_n      = up;
    upd_ev    = 1'b0;
    bottom_ev = 1'b0;
    ovf_ev    = 1'b0;
    if (step) begin
      if (is_phase(mode)) begin
        if (up) begin
          if (cnt >= top) begin
            up_n   = 1'b0;
            cnt_n  = (cnt == '0) ? '0 : cnt - ONE;
            upd_ev = 1'b1;
          end else begin
            cnt_n = cnt + ONE;
          end
        end else if (cnt == '0) begin
          up_n   = 1'b1;
          cnt_n  = (top == '0) ? '0 : ONE;
          ovf_ev = 1'b1;
        end else begin
          cnt_n = cnt - ONE;
        end
      end else begin
        up_n  = 1'b1;
        cnt_n = at_top ? '0 : cnt + ONE;
        if (is_fast(mode)) begin
          bottom_ev = at_top || (cnt == MAXV);
          upd_ev    = bottom_ev;
        end
        ovf_ev = (mode == M_FAST_VAR) ? at_top : (cnt == MAXV);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (ld) begin
      cnt <= ld_val;
    end else begin
      cnt <= cnt_n;
      up  <= up_n;
    end
  end

  // R4: a tick at compare A in clear-on-compare mode brings the count to zero
  p_ctc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == M_CTC && cnt == top_var) |=> (cnt == '0));

  // R6: counting down moves by exactly one
  p_phase_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_phase(mode) && !up && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  // R14: reserved modes hold the counter
  p_rsv_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && is_rsv(mode)) |=> $stable(cnt));

endmodule

// File: rtl/wt_channel.sv
module wt_channel
  import wt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wt_mode_e         mode,
  input  wt_act_e          act,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  input  logic             upd_ev,
  input  logic             bottom_ev,
  input  logic             up,
  input  logic [CNT_W-1:0] cnt,
  input  logic             blk,
  input  logic             force_i,
  output logic [CNT_W-1:0] active,
  output logic             pin,
  output logic             oe,
  output logic             match
);

  logic [CNT_W-1:0] shadow, newest;
  logic             pin_n;

  assign newest = wr ? wdata : shadow;
  assign match  = step & ~blk & (cnt == active);
  assign oe     = (act != ACT_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      shadow <= newest;
      if (!is_pwm(mode) || upd_ev) active <= newest;
    end
  end

  always_comb begin
    pin_n = pin;
    if (!is_pwm(mode)) begin
      if (match || force_i) begin
        unique case (act)
          ACT_TOGGLE: pin_n = ~pin;
          ACT_LOW:    pin_n = 1'b0;
          ACT_HIGH:   pin_n = 1'b1;
          default:    pin_n = pin;
        endcase
      end
    end else if (act == ACT_TOGGLE) begin
      if (match) pin_n = ~pin;
    end else if (act != ACT_OFF) begin
      if (is_fast(mode)) begin
        if (bottom_ev)  pin_n = (act == ACT_LOW);
        else if (match) pin_n = (act == ACT_HIGH);
      end else if (match) begin
        pin_n = up ? (act == ACT_HIGH) : (act == ACT_LOW);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_n;
  end

  // R7: a buffered write with no update point leaves the value in effect alone
  p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_pwm(mode) && !upd_ev) |=> $stable(active));

  // R12: a force strobe in a PWM mode changes nothing on the pin
  p_force_pwm_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && is_pwm(mode) && !match && !bottom_ev) |=> $stable(pin));

  // R9: a disconnected channel keeps its pin value
  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_OFF) |=> $stable(pin));

endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             pin_a,
  output logic             pin_b,
  output logic             oe_a,
  output logic             oe_b,
  output logic [2:0]       flags
);

  localparam int NCH = 2;

  logic [7:0]       ctrl_q;
  logic [2:0]       flags_q, set_v, clr_v;
  logic             blk_q, cnt_wr;
  wt_mode_e         mode;
  logic [CNT_W-1:0] cnt;
  logic             up, step, upd_ev, bottom_ev, ovf_ev;
  logic [CNT_W-1:0] act_cmp [NCH];
  logic [NCH-1:0]   ch_pin, ch_oe, ch_match;

  assign mode   = wt_mode_e'(ctrl_q[2:0]);
  assign cnt_wr = reg_wr && (reg_addr == A_CNT);

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .top_var(act_cmp[0]),
    .ld(cnt_wr), .ld_val(reg_wdata), .cnt(cnt), .up(up), .step(step),
    .upd_ev(upd_ev), .bottom_ev(bottom_ev), .ovf_ev(ovf_ev)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .act(wt_act_e'(ctrl_q[4+2*i +: 2])),
      .wr(reg_wr && (reg_addr == A_CMPA + 3'(i))),
      .wdata(reg_wdata), .step(step), .upd_ev(upd_ev), .bottom_ev(bottom_ev),
      .up(up), .cnt(cnt), .blk(blk_q),
      .force_i(reg_wr && (reg_addr == A_FORCE) && reg_wdata[i]),
      .active(act_cmp[i]), .pin(ch_pin[i]), .oe(ch_oe[i]), .match(ch_match[i])
    );
  end

  assign set_v = {ch_match[1], ch_match[0], ovf_ev};
  assign clr_v = (reg_wr && reg_addr == A_FLAGS) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      blk_q   <= 1'b0;
    end else begin
      blk_q   <= cnt_wr;
      flags_q <= (flags_q & ~clr_v) | set_v;
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[7:0];
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CNT:   reg_rdata = cnt;
      A_CMPA:  reg_rdata = act_cmp[0];
      A_CMPB:  reg_rdata = act_cmp[1];
      A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      A_FLAGS: reg_rdata = CNT_W'(flags_q);
      default: reg_rdata = '0;
    endcase
  end

  assign pin_a = ch_pin[0];
  assign pin_b = ch_pin[1];
  assign oe_a  = ch_oe[0];
  assign oe_b  = ch_oe[1];
  assign flags = flags_q;

  // R8: a hardware overflow set survives a same-cycle clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_v[0] |=> flags_q[0]);

  // R13: a counter write keeps match A from setting its flag for two edges
  p_wr_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !flags_q[1]) |-> ##2 !flags_q[1]);

endmodule

// File: tb/wave_timer_tb_top.sv
`timescale 1ns/10ps
module wave_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       pin_a, pin_b, oe_a, oe_b;
  logic [2:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wave_timer #(.CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_a(pin_a), .pin_b(pin_b),
    .oe_a(oe_a), .oe_b(oe_b), .flags(flags)
  );

  // reference state
  logic [7:0] m_cnt, m_ctrl;
  logic       m_up, m_blk;
  logic [7:0] m_buf [2];
  logic [7:0] m_act [2];
  logic [1:0] m_pin;
  logic [2:0] m_flags;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ctrl = 0; m_up = 1; m_blk = 0;
    m_buf[0] = 0; m_buf[1] = 0; m_act[0] = 0; m_act[1] = 0;
    m_pin = 0; m_flags = 0;
  endtask

  task automatic model_edge(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    logic [2:0] md;
    logic ph, fs, rsv, pwm, vt, ld, stp, upd, bot, ovf;
    logic [7:0] top, ncnt;
    logic nup;
    logic [1:0] mt, frc, np;
    logic [7:0] nw [2];
    logic [1:0] ac;
    logic [2:0] clr;
    md  = m_ctrl[2:0];
    ph  = (md == 3'b001) || (md == 3'b101);
    fs  = (md == 3'b011) || (md == 3'b111);
    rsv = (md == 3'b100) || (md == 3'b110);
    pwm = ph || fs;
    vt  = (md == 3'b010) || (md == 3'b101) || (md == 3'b111);
    top = vt ? m_act[0] : 8'hFF;
    ld  = w && (a == 3'd0);
    stp = t && !ld && !rsv;
    ncnt = m_cnt; nup = m_up; upd = 0; bot = 0; ovf = 0;
    if (stp) begin
      if (ph) begin
        if (m_up) begin
          if (m_cnt >= top) begin nup = 0; ncnt = (m_cnt == 0) ? 8'd0 : m_cnt - 8'd1; upd = 1; end
          else ncnt = m_cnt + 8'd1;
        end else if (m_cnt == 0) begin
          nup = 1; ncnt = (top == 0) ? 8'd0 : 8'd1; ovf = 1;
        end else ncnt = m_cnt - 8'd1;
      end else begin
        nup = 1;
        ncnt = (m_cnt == top) ? 8'd0 : m_cnt + 8'd1;
        if (fs) begin bot = (m_cnt == top) || (m_cnt == 8'hFF); upd = bot; end
        ovf = (md == 3'b111) ? (m_cnt == top) : (m_cnt == 8'hFF);
      end
    end
    for (int i = 0; i < 2; i++) begin
      mt[i]  = stp && !m_blk && (m_cnt == m_act[i]);
      frc[i] = w && (a == 3'd5) && d[i];
      nw[i]  = (w && a == 3'(i + 1)) ? d : m_buf[i];
      ac     = (i == 0) ? m_ctrl[5:4] : m_ctrl[7:6];
      np[i]  = m_pin[i];
      if (!pwm) begin
        if (mt[i] || frc[i]) begin
          if (ac == 2'b01) np[i] = ~m_pin[i];
          else if (ac == 2'b10) np[i] = 1'b0;
          else if (ac == 2'b11) np[i] = 1'b1;
        end
      end else if (ac == 2'b01) begin
        if (mt[i]) np[i] = ~m_pin[i];
      end else if (ac != 2'b00) begin
        if (fs) begin
          if (bot) np[i] = (ac == 2'b10);
          else if (mt[i]) np[i] = (ac == 2'b11);
        end else if (mt[i]) np[i] = m_up ? (ac == 2'b11) : (ac == 2'b10);
      end
    end
    clr = (w && a == 3'd4) ? d[2:0] : 3'b000;
    m_flags = (m_flags & ~clr) | {mt[1], mt[0], ovf};
    for (int i = 0; i < 2; i++) begin
      if (!pwm || upd) m_act[i] = nw[i];
      m_buf[i] = nw[i];
    end
    m_pin = np;
    m_blk = ld;
    if (ld) m_cnt = d;
    else begin m_cnt = ncnt; m_up = nup; end
    if (w && a == 3'd3) m_ctrl = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.3;
    v = reg_rdata;
  endtask

  task automatic compare_all();
    logic [7:0] v;
    check("R9 R10 R11 R12 pins", {pin_b, pin_a}, m_pin);
    check("R9 oe", {oe_b, oe_a}, {m_ctrl[7:6] != 2'b00, m_ctrl[5:4] != 2'b00});
    check("R8 flags", flags, m_flags);
    rd(3'd0, v); check("R3 R4 R5 R6 R13 R14 counter", v, m_cnt);
    rd(3'd1, v); check("R7 compare A", v, m_act[0]);
    rd(3'd2, v); check("R7 compare B", v, m_act[1]);
  endtask

  task automatic cycle(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
    model_edge(t, w, a, d);
    @(posedge clk);
    #1;
    reg_wr = 0; tick = 0;
    compare_all();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin : stim
    logic [7:0] v;
    logic [2:0] modes [7] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd7, 3'd4};
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    // R2 / R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 R2 reset register", v, 8'h00);
    end
    check("R2 reset pins", {oe_b, oe_a, pin_b, pin_a, flags}, 7'd0);

    // R3 normal counting and overflow
    cycle(0, 1, 0, 8'hFE);
    cycle(0, 0, 0, 0); cycle(0, 0, 0, 0);
    rd(0, v); check("R3 hold without tick", v, 8'hFE);
    cycle(1, 0, 0, 0);
    rd(0, v); check("R3 step", v, 8'hFF);
    cycle(1, 0, 0, 0);
    rd(0, v); check("R3 wrap", v, 8'h00);
    check("R3 overflow flag", flags, 3'b001);

    // R8 clear and set-wins
    cycle(1, 1, 4, 8'h01);
    check("R8 clear with new matches", flags, 3'b110);
    cycle(0, 1, 4, 8'h06);
    check("R8 clear all", flags, 3'b000);
    cycle(0, 1, 0, 8'hFF);
    cycle(1, 1, 4, 8'h01);
    check("R8 set wins over clear", flags[0], 1'b1);
    cycle(0, 1, 4, 8'h07);

    // R4 clear-on-compare
    cycle(0, 1, 1, 8'h05);
    cycle(0, 1, 3, 8'h02);
    cycle(0, 1, 4, 8'h07);
    repeat (6) cycle(1, 0, 0, 0);
    rd(0, v); check("R4 clear at compare A", v, 8'h00);
    check("R4 match A no overflow", flags[1:0], 2'b10);

    // R7 fast PWM buffered update, then phase-correct
    cycle(0, 1, 4, 8'h07);
    cycle(0, 1, 3, 8'h03);
    cycle(0, 1, 1, 8'h40);
    rd(1, v); check("R7 fast write held", v, 8'h05);
    cycle(0, 1, 0, 8'hFF);
    cycle(1, 0, 0, 0);
    rd(1, v); check("R7 fast update at bottom", v, 8'h40);
    cycle(0, 1, 3, 8'h01);
    cycle(0, 1, 1, 8'h10);
    rd(1, v); check("R7 phase write held", v, 8'h40);
    cycle(0, 1, 0, 8'hFF);
    cycle(1, 0, 0, 0);
    rd(1, v); check("R7 phase update at TOP", v, 8'h10);
    rd(0, v); check("R6 turn down at TOP", v, 8'hFE);
    cycle(0, 1, 0, 8'h01);
    cycle(0, 1, 4, 8'h07);
    cycle(1, 0, 0, 0);
    cycle(1, 0, 0, 0);
    rd(0, v); check("R6 turn up at bottom", v, 8'h01);
    check("R6 overflow at bottom", flags[0], 1'b1);

    // R12 force
    cycle(0, 1, 3, 8'h10);
    cycle(0, 1, 4, 8'h07);
    rd(0, v);
    cycle(0, 1, 5, 8'h01);
    check("R12 force toggles", {oe_a, pin_a}, 2'b11);
    check("R12 force sets no flag", flags, 3'b000);
    begin
      logic [7:0] v2;
      rd(0, v2); check("R12 force keeps counter", v2, v);
    end
    cycle(0, 1, 3, 8'h13);
    cycle(0, 1, 5, 8'h01);
    check("R12 force ignored in PWM", pin_a, 1'b1);

    // R13 counter write blocks the next match
    cycle(0, 1, 3, 8'h00);
    cycle(0, 1, 4, 8'h07);
    cycle(0, 1, 0, 8'h10);
    cycle(1, 0, 0, 0);
    check("R13 match suppressed", flags, 3'b000);
    rd(0, v); check("R13 counted past", v, 8'h11);

    // R14 reserved
    cycle(0, 1, 3, 8'h04);
    repeat (3) cycle(1, 0, 0, 0);
    rd(0, v); check("R14 reserved holds", v, 8'h11);

    // R9 drive low on match
    cycle(0, 1, 3, 8'h20);
    cycle(0, 1, 0, 8'h0F);
    cycle(1, 0, 0, 0);
    cycle(1, 0, 0, 0);
    check("R9 drive low on match", pin_a, 1'b0);

    // random segment against the model (R5 R6 R9 R10 R11 and the rest)
    for (int n = 0; n < 4000; n++) begin
      logic t, w;
      logic [2:0] a;
      logic [7:0] d;
      t = ($urandom % 4) != 0;
      w = 0; a = 0; d = 0;
      if (n % 400 == 0) begin
        w = 1; a = 3'd3;
        d = {4'($urandom), 1'b0, modes[$urandom % 7]};
      end else if ($urandom % 12 == 0) begin
        w = 1;
        case ($urandom % 8)
          0:       a = 3'd0;
          1, 2:    a = 3'd1;
          3, 4:    a = 3'd2;
          5:       a = 3'd4;
          default: a = 3'd5;
        endcase
        case ($urandom % 4)
          0:       d = 8'hFF;
          1:       d = 8'($urandom % 16);
          default: d = 8'($urandom);
        endcase
      end
      cycle(t, w, a, d);
    end

    done = 1'b1;
    finish_run();
  end

endmodule